// File: doc/BRIEF.md
# Operand Bypass and Load-Interlock Controller

This block sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it compares the two source register numbers of the instruction being decoded against the destination registers of the two older instructions now in execute and in memory access. From those matches it chooses, for each ALU operand, where the execute stage will take its value next cycle: the register file, the result one stage ahead, or the result two stages ahead. The choices are registered, so they reach execute together with the decoded instruction.

When the instruction in execute is a load and its destination is needed by decode, the loaded value cannot be bypassed in time. The block then holds the program counter and the fetch/decode register and turns the next execute slot into a bubble. One cycle later the load sits in memory access and its data is bypassed from the far path. A producer three instructions back needs no action, because the register file writes early in the cycle and reads late in it.

A mode input switches bypassing off. In that mode every match with a writing instruction in execute or memory access stalls decode, so a back-to-back dependence costs two bubbles. This lets both pipeline flavours be built and checked from one block.

Top module: `hz_unit`

## Requirements
- R1: With bypassing on and no stall, a source that equals the destination of a writing instruction in execute gets select code 1 (near result) on its operand output one clock edge later; operand A follows the first source, operand B the second.
- R2: With bypassing on and no stall, a source that matches only the destination of a writing instruction in memory access gets select code 2 (far result) one edge later; a source with no match gets code 0 (register file).
- R3: When a source matches both the execute and the memory-access destinations, code 1 wins.
- R4: Register number 0 never produces a bypass code or a stall.
- R5: A destination whose write enable is low never matches.
- R6: With bypassing on, a writing load in execute whose destination equals either nonzero source raises the hold and bubble outputs in the same cycle; both operand codes are 0 after that edge, and once the load has moved to memory access the dependent operand gets code 2, for a total of one stall cycle.
- R7: With bypassing off, any match with a writing instruction in execute or memory access raises hold and bubble, the operand codes stay 0, and a back-to-back dependence stalls exactly two cycles.
- R8: An active-low reset clears both operand codes to 0 at once.
- R9: Hold and bubble are combinational and always equal; with no qualifying match both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en_i | input | 1 | 1 = bypassing on, 0 = stall on every hazard |
| id_rs_i | input | REG_AW | First source register of the decode instruction |
| id_rt_i | input | REG_AW | Second source register of the decode instruction |
| ex_rd_i | input | REG_AW | Destination of the instruction in execute |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction reads data memory |
| mem_rd_i | input | REG_AW | Destination of the instruction in memory access |
| mem_we_i | input | 1 | Memory-access instruction writes a register |
| fwd_a_o | output | 2 | Operand A source code for execute (0 file, 1 near, 2 far) |
| fwd_b_o | output | 2 | Operand B source code for execute (0 file, 1 near, 2 far) |
| hold_o | output | 1 | Freeze program counter and fetch/decode register |
| bubble_o | output | 1 | Clear the control fields entering execute |

## Verification
A vector table applies isolated near matches, isolated far matches, double matches on one register, hits on both operands at once, register-0 and disabled-write cases, and load cases that do or do not touch a source. Each row tells the code choice and priority apart from a stall decision, in both modes. Directed sequences then move a producer down the pipeline cycle by cycle to tell a two-bubble interlock (bypassing off) from a one-bubble load interlock followed by a far bypass, and a reset is applied while a code is live.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_FILE = 2'd0,
      SRC_NEAR = 2'd1,
      SRC_FAR  = 2'd2
   } src_sel_e;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
   parameter int REG_AW   = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_we_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_we_i,
   output logic              near_hit_o,
   output logic              far_hit_o
);

   logic src_live;

   generate
      if (ZERO_REG) begin : g_zero_hard
         assign src_live = |src_i;
      end else begin : g_zero_soft
         assign src_live = 1'b1;
      end
   endgenerate

   assign near_hit_o = src_live && ex_we_i  && (ex_rd_i  == src_i);
   assign far_hit_o  = src_live && mem_we_i && (mem_rd_i == src_i);

endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
   parameter int NUM_SRC = 2
) (
   input  logic               fwd_en_i,
   input  logic               ex_load_i,
   input  logic [NUM_SRC-1:0] near_hit_i,
   input  logic [NUM_SRC-1:0] far_hit_i,
   output logic               stall_o
);

   logic load_use;
   logic any_hazard;

   assign load_use   = ex_load_i && (|near_hit_i);
   assign any_hazard = (|near_hit_i) || (|far_hit_i);

   always_comb begin
      if (fwd_en_i) stall_o = load_use;
      else          stall_o = any_hazard;
   end

endmodule

// File: rtl/hz_sel_reg.sv
module hz_sel_reg
   import hz_pkg::*;
#(
   parameter int NUM_SRC = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fwd_en_i,
   input  logic                          stall_i,
   input  logic [NUM_SRC-1:0]            near_hit_i,
   input  logic [NUM_SRC-1:0]            far_hit_i,
   output logic [NUM_SRC-1:0][SEL_W-1:0] sel_o
);

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         src_sel_e sel_d;
         src_sel_e sel_q;

         always_comb begin
            sel_d = SRC_FILE;
            if (fwd_en_i && !stall_i) begin
               if (near_hit_i[g])     sel_d = SRC_NEAR;
               else if (far_hit_i[g]) sel_d = SRC_FAR;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= SRC_FILE;
            else        sel_q <= sel_d;
         end

         assign sel_o[g] = sel_q;
      end
   endgenerate

endmodule

// File: rtl/hz_unit.sv
module hz_unit
   import hz_pkg::*;
#(
   parameter int REG_AW   = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd_en_i,
   input  logic [REG_AW-1:0] id_rs_i,
   input  logic [REG_AW-1:0] id_rt_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_we_i,
   input  logic              ex_load_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_we_i,
   output logic [SEL_W-1:0]  fwd_a_o,
   output logic [SEL_W-1:0]  fwd_b_o,
   output logic              hold_o,
   output logic              bubble_o
);

   localparam int NUM_SRC = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hz_unit: REG_AW must lie in 1..8");
      end
   endgenerate

   logic [NUM_SRC-1:0][REG_AW-1:0] src;
   logic [NUM_SRC-1:0]             near_hit;
   logic [NUM_SRC-1:0]             far_hit;
   logic [NUM_SRC-1:0][SEL_W-1:0]  sel;
   logic                           stall;

   assign src[0] = id_rs_i;
   assign src[1] = id_rt_i;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
         hz_match #(
            .REG_AW  (REG_AW),
            .ZERO_REG(ZERO_REG)
         ) u_match (
            .src_i     (src[g]),
            .ex_rd_i   (ex_rd_i),
            .ex_we_i   (ex_we_i),
            .mem_rd_i  (mem_rd_i),
            .mem_we_i  (mem_we_i),
            .near_hit_o(near_hit[g]),
            .far_hit_o (far_hit[g])
         );
      end
   endgenerate

   hz_stall #(.NUM_SRC(NUM_SRC)) u_stall (
      .fwd_en_i  (fwd_en_i),
      .ex_load_i (ex_load_i),
      .near_hit_i(near_hit),
      .far_hit_i (far_hit),
      .stall_o   (stall)
   );

   hz_sel_reg #(.NUM_SRC(NUM_SRC)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .fwd_en_i  (fwd_en_i),
      .stall_i   (stall),
      .near_hit_i(near_hit),
      .far_hit_i (far_hit),
      .sel_o     (sel)
   );

   assign fwd_a_o  = sel[0];
   assign fwd_b_o  = sel[1];
   assign hold_o   = stall;
   assign bubble_o = stall;

endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fwd_en_i,
   input logic [REG_AW-1:0] id_rs_i,
   input logic [REG_AW-1:0] id_rt_i,
   input logic [REG_AW-1:0] ex_rd_i,
   input logic              ex_we_i,
   input logic              ex_load_i,
   input logic [REG_AW-1:0] mem_rd_i,
   input logic              mem_we_i,
   input logic [1:0]        fwd_a_o,
   input logic [1:0]        fwd_b_o,
   input logic              hold_o,
   input logic              bubble_o
);

   // R1: an execute-stage writer matching the first source yields near code
   a_r1_near_a: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en_i && ex_we_i && id_rs_i != '0 && ex_rd_i == id_rs_i && !hold_o)
      |=> (fwd_a_o == 2'd1));

   // R1: codes stay within the defined set
   a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a_o != 2'd3) && (fwd_b_o != 2'd3));

   // R2: a memory-stage-only match on the second source yields far code
   a_r2_far_b: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en_i && mem_we_i && id_rt_i != '0 && mem_rd_i == id_rt_i
       && !(ex_we_i && ex_rd_i == id_rt_i) && !hold_o)
      |=> (fwd_b_o == 2'd2));

   // R4: register 0 is never bypassed
   a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs_i == '0) |=> (fwd_a_o == 2'd0));

   // R6: load in execute feeding decode forces the interlock
   a_r6_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en_i && ex_load_i && ex_we_i && ex_rd_i != '0
       && (ex_rd_i == id_rs_i || ex_rd_i == id_rt_i)) |-> (hold_o && bubble_o));

   // R6: the slot after a stall carries no bypass
   a_r6_bubble_clean: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));

   // R7: with bypassing off no code is ever issued
   a_r7_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_en_i |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));

   // R7: with bypassing off an execute-stage match stalls
   a_r7_ex_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_en_i && ex_we_i && id_rs_i != '0 && ex_rd_i == id_rs_i) |-> hold_o);

endmodule

bind hz_unit hz_unit_chk #(.REG_AW(REG_AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fwd_en_i (fwd_en_i),
   .id_rs_i  (id_rs_i),
   .id_rt_i  (id_rt_i),
   .ex_rd_i  (ex_rd_i),
   .ex_we_i  (ex_we_i),
   .ex_load_i(ex_load_i),
   .mem_rd_i (mem_rd_i),
   .mem_we_i (mem_we_i),
   .fwd_a_o  (fwd_a_o),
   .fwd_b_o  (fwd_b_o),
   .hold_o   (hold_o),
   .bubble_o (bubble_o)
);

// File: tb/tb_hz_unit.sv
module tb_hz_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fwd_en_i = 1'b1;
   logic [4:0] id_rs_i = '0, id_rt_i = '0, ex_rd_i = '0, mem_rd_i = '0;
   logic       ex_we_i = 1'b0, ex_load_i = 1'b0, mem_we_i = 1'b0;
   logic [1:0] fwd_a_o, fwd_b_o;
   logic       hold_o, bubble_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   hz_unit dut (.*);

   typedef struct packed {
      logic       en;
      logic [4:0] rs;
      logic [4:0] rt;
      logic [4:0] exrd;
      logic       exwe;
      logic       exld;
      logic [4:0] memrd;
      logic       memwe;
      logic       stall;
      logic [1:0] a;
      logic [1:0] b;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      // en rs     rt     exrd   we   ld   memrd  mwe  stall a     b
      '{1'b1,5'd1, 5'd2, 5'd3, 1'b1,1'b0,5'd4, 1'b1,1'b0,2'd0,2'd0}, // R2 no match -> file
      '{1'b1,5'd3, 5'd2, 5'd3, 1'b1,1'b0,5'd4, 1'b1,1'b0,2'd1,2'd0}, // R1 near on A
      '{1'b1,5'd1, 5'd4, 5'd3, 1'b1,1'b0,5'd4, 1'b1,1'b0,2'd0,2'd2}, // R2 far on B
      '{1'b1,5'd5, 5'd1, 5'd5, 1'b1,1'b0,5'd5, 1'b1,1'b0,2'd1,2'd0}, // R3 near wins
      '{1'b1,5'd0, 5'd0, 5'd0, 1'b1,1'b0,5'd0, 1'b1,1'b0,2'd0,2'd0}, // R4 reg 0
      '{1'b1,5'd3, 5'd7, 5'd3, 1'b0,1'b0,5'd7, 1'b0,1'b0,2'd0,2'd0}, // R5 we low
      '{1'b1,5'd6, 5'd2, 5'd6, 1'b1,1'b1,5'd0, 1'b0,1'b1,2'd0,2'd0}, // R6 load-use A
      '{1'b1,5'd1, 5'd6, 5'd6, 1'b1,1'b1,5'd0, 1'b0,1'b1,2'd0,2'd0}, // R6 load-use B
      '{1'b1,5'd1, 5'd2, 5'd6, 1'b1,1'b1,5'd0, 1'b0,1'b0,2'd0,2'd0}, // R9 load no use
      '{1'b1,5'd0, 5'd2, 5'd0, 1'b1,1'b1,5'd0, 1'b0,1'b0,2'd0,2'd0}, // R4 load to r0
      '{1'b0,5'd3, 5'd2, 5'd3, 1'b1,1'b0,5'd4, 1'b1,1'b1,2'd0,2'd0}, // R7 ex match
      '{1'b0,5'd1, 5'd4, 5'd3, 1'b1,1'b0,5'd4, 1'b1,1'b1,2'd0,2'd0}, // R7 mem match
      '{1'b0,5'd0, 5'd0, 5'd0, 1'b1,1'b0,5'd0, 1'b1,1'b0,2'd0,2'd0}, // R7/R4 r0 only
      '{1'b1,5'd3, 5'd4, 5'd3, 1'b1,1'b0,5'd4, 1'b1,1'b0,2'd1,2'd2}  // R1/R2 both ops
   };

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic drive(input logic en, input logic [4:0] rs, input logic [4:0] rt,
                        input logic [4:0] exrd, input logic exwe, input logic exld,
                        input logic [4:0] memrd, input logic memwe);
      fwd_en_i = en; id_rs_i = rs; id_rt_i = rt; ex_rd_i = exrd;
      ex_we_i = exwe; ex_load_i = exld; mem_rd_i = memrd; mem_we_i = memwe;
   endtask

   initial begin
      #2000000;
      total++; bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int stalls;
      // R8 reset state
      repeat (2) @(negedge clk);
      check("R8 reset A", fwd_a_o, 0);
      check("R8 reset B", fwd_b_o, 0);
      check("R9 reset hold", hold_o, 0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i].en, VEC[i].rs, VEC[i].rt, VEC[i].exrd, VEC[i].exwe,
               VEC[i].exld, VEC[i].memrd, VEC[i].memwe);
         #1;
         check($sformatf("R6/R7/R9 hold vec%0d", i), hold_o, VEC[i].stall);
         check($sformatf("R9 bubble vec%0d", i), bubble_o, VEC[i].stall);
         @(posedge clk); #1;
         check($sformatf("R1/R2/R3 A vec%0d", i), fwd_a_o, VEC[i].a);
         check($sformatf("R1/R2/R3 B vec%0d", i), fwd_b_o, VEC[i].b);
      end

      // R7 back-to-back dependence with bypassing off: two bubbles
      stalls = 0;
      @(negedge clk); drive(1'b0, 5'd8, 5'd0, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0);
      #1 stalls += int'(hold_o);
      @(negedge clk); drive(1'b0, 5'd8, 5'd0, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1);
      #1 stalls += int'(hold_o);
      @(negedge clk); drive(1'b0, 5'd8, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0);
      #1 stalls += int'(hold_o);
      check("R7 bubble count", stalls, 2);

      // R6 load then dependent add with bypassing on: one bubble, then far
      stalls = 0;
      @(negedge clk); drive(1'b1, 5'd9, 5'd0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0);
      #1 stalls += int'(hold_o);
      @(posedge clk); #1;
      check("R6 A after stall", fwd_a_o, 0);
      @(negedge clk); drive(1'b1, 5'd9, 5'd0, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1);
      #1 stalls += int'(hold_o);
      @(posedge clk); #1;
      check("R6 A far after stall", fwd_a_o, 2);
      check("R6 bubble count", stalls, 1);

      // R8 asynchronous reset clears a live code
      @(negedge clk); drive(1'b1, 5'd3, 5'd3, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0);
      @(posedge clk); #1;
      check("R1 live code before reset", fwd_a_o, 1);
      #2 rst_n = 1'b0;
      #1;
      check("R8 async clear A", fwd_a_o, 0);
      check("R8 async clear B", fwd_b_o, 0);
      @(negedge clk); rst_n = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule